// File: doc/BRIEF.md
# SAR Conversion Sequencer

This block holds the digital control around a 12-bit successive-approximation converter. A one-cycle start request launches a conversion. The block divides the system clock down to a converter clock, holds the sample switch closed for a programmable number of converter clocks, and then runs twelve bit trials, MSB first, against a single-bit comparator input. Seven further converter clocks cover settling and the result write. The trial level is driven out as a 12-bit code for the external DAC. The comparator reports whether the sampled input is at or above that level.

The result goes into a 32-bit data word. It is straight binary in single-ended and pseudo-differential modes. In fully differential mode it is two's complement with the sign replicated above it. A ready flag, visible as a level interrupt, marks a fresh result, and reading the data word clears it. One channel index is reserved for the temperature sensor. A conversion on that channel forces a long acquisition and a slow divider. The programmed timing applies again on the next conversion. A write to the soft-reset address restores every register and abandons any conversion in progress.

Top module: `sar_conv_seq`

## Requirements
- R1: After reset, the control word (address 0) reads 0x00020080: enable bit 0 = 0, mode bits 2:1 = 0, acquisition count bits 11:4 = 8, divider bits 23:16 = 2. The channel words (addresses 1 and 2), the status word (address 3) and the data word (address 4) read 0, and busy and irq are low.
- R2: A start request is accepted only when the enable bit is 1 and busy is low. Busy rises on the following cycle and stays high for exactly (A+19)×D system cycles, where A is the acquisition count and D is the divider.
- R3: A start request while busy is high is ignored. The running conversion keeps its length and no second conversion follows.
- R4: sampleEn is high for the first A×D cycles of busy. An acquisition count or divider programmed as 0 behaves as 1.
- R5: When the positive channel word equals 9 at the start, the conversion uses A=16 and D=32 whatever is programmed. The next conversion on another channel uses the programmed A and D.
- R6: The bit trials run MSB first, one converter clock each. trialCode shows the bits kept so far plus the bit under trial. A bit is kept when cmpIn is 1, meaning the input is at or above the trial level.
- R7: In modes 0, 1 and 3, the data word carries the 12-bit code in bits 27:16, and bits 31:28 and 15:0 are zero.
- R8: In mode 2 (fully differential), bits 27:16 hold the code with its MSB inverted, as two's complement around mid-scale 0x800. Bits 31:28 copy bit 27, and bits 15:0 are zero.
- R9: Status bit 0 (ready) is set on the cycle busy falls at the end of a conversion. irq is high exactly while ready is set.
- R10: Reading the data word (regRdEn at address 4) clears ready. When a conversion ends on the same cycle as the read, ready stays set.
- R11: A write to address 5 returns all registers to their reset values, drops busy on the next cycle, and produces no result.
- R12: Timing and mode are captured at the start. Writes to the control word during a conversion change neither its length nor its result format.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (read side effects) |
| regAddr | input | 3 | Register address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data, combinational from regAddr |
| convStart | input | 1 | Start-of-conversion request |
| cmpIn | input | 1 | Comparator: 1 when the input is at or above trialCode |
| trialCode | output | 12 | Code driven to the DAC |
| sampleEn | output | 1 | Acquisition phase (sample switch closed) |
| busy | output | 1 | Conversion in progress |
| irq | output | 1 | Level interrupt, equal to ready |
| chanPos | output | 4 | Positive channel select |
| chanNeg | output | 4 | Negative channel select |

## Verification
The bench sweeps input codes in both number formats, including the exact-match trial where a strict comparison would lose one LSB and the mid-scale point where a wrong sign flip would swap positive and negative full scale. It measures busy and acquisition lengths across several timing settings, including zero values and the temperature override. It then confirms that the override is dropped on the next channel; a sequencer that stored the forced values would keep converting slowly. It also lines a data read up with the last conversion cycle, restarts and control writes mid-conversion, and a soft reset mid-conversion. A faulty sequencer would lose a fresh result, restart or stretch a conversion, or leave a stale ready bit behind.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  localparam int SAR_BITS    = 12;
  localparam int IDX_W       = $clog2(SAR_BITS);
  localparam int SETTLE_CLKS = 7;
  localparam int EXTRA_CLKS  = SAR_BITS + SETTLE_CLKS;
  localparam int DATA_W      = 32;
  localparam int DATA_LSB    = 16;
  localparam int SIGN_W      = DATA_W - DATA_LSB - SAR_BITS;

  localparam logic [2:0] ADDR_CTRL = 3'd0;
  localparam logic [2:0] ADDR_POS  = 3'd1;
  localparam logic [2:0] ADDR_NEG  = 3'd2;
  localparam logic [2:0] ADDR_STAT = 3'd3;
  localparam logic [2:0] ADDR_DATA = 3'd4;
  localparam logic [2:0] ADDR_SRST = 3'd5;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'd0,
    MODE_PSEUDO = 2'd1,
    MODE_DIFF   = 2'd2,
    MODE_SPARE  = 2'd3
  } inMode_e;

  typedef struct packed {
    logic             startStb;
    logic             trialActive;
    logic             trialStb;
    logic [IDX_W-1:0] trialIdx;
    logic             writeStb;
    logic             diffMode;
  } seqStrobe_t;

endpackage

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int ACQ_W    = 8,
  parameter int DIV_W    = 8,
  parameter int CH_W     = 4,
  parameter int TEMP_CH  = 9,
  parameter int TEMP_ACQ = 16,
  parameter int TEMP_DIV = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             softRst,
  input  logic             convStart,
  input  logic             cfgEnable,
  input  inMode_e          cfgMode,
  input  logic [ACQ_W-1:0] cfgAcq,
  input  logic [DIV_W-1:0] cfgDiv,
  input  logic [CH_W-1:0]  cfgPos,
  output seqStrobe_t       strb,
  output logic             busy,
  output logic             sampleEn
);

  localparam int TICK_W = $clog2((1 << ACQ_W) + EXTRA_CLKS + 1);
  localparam logic [TICK_W-1:0] LAST_OFS  = TICK_W'(EXTRA_CLKS - 1);
  localparam logic [TICK_W-1:0] TRIAL_CNT = TICK_W'(SAR_BITS);

  logic             busyQ;
  logic [DIV_W-1:0] divCnt;
  logic [TICK_W-1:0] tickCnt;
  logic [ACQ_W-1:0] effAcq;
  logic [DIV_W-1:0] effDiv;
  logic             diffQ;

  logic              startOk, isTemp, divTick, lastTick, inAcq, inTrial;
  logic [TICK_W-1:0] acqExt, trialOfs;
  logic [ACQ_W-1:0]  nextAcq;
  logic [DIV_W-1:0]  nextDiv;

  assign isTemp  = (cfgPos == CH_W'(TEMP_CH));
  assign startOk = convStart && cfgEnable && !busyQ;
  assign nextAcq = isTemp ? ACQ_W'(TEMP_ACQ) : ((cfgAcq == '0) ? ACQ_W'(1) : cfgAcq);
  assign nextDiv = isTemp ? DIV_W'(TEMP_DIV) : ((cfgDiv == '0) ? DIV_W'(1) : cfgDiv);

  assign acqExt   = TICK_W'(effAcq);
  assign trialOfs = tickCnt - acqExt;
  assign divTick  = busyQ && (divCnt == effDiv - DIV_W'(1));
  assign lastTick = (tickCnt == acqExt + LAST_OFS);
  assign inAcq    = (tickCnt < acqExt);
  assign inTrial  = !inAcq && (trialOfs < TRIAL_CNT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ   <= 1'b0;
      divCnt  <= '0;
      tickCnt <= '0;
      effAcq  <= '0;
      effDiv  <= DIV_W'(1);
      diffQ   <= 1'b0;
    end else if (softRst) begin
      busyQ   <= 1'b0;
      divCnt  <= '0;
      tickCnt <= '0;
      effAcq  <= '0;
      effDiv  <= DIV_W'(1);
      diffQ   <= 1'b0;
    end else if (startOk) begin
      busyQ   <= 1'b1;
      divCnt  <= '0;
      tickCnt <= '0;
      effAcq  <= nextAcq;
      effDiv  <= nextDiv;
      diffQ   <= (cfgMode == MODE_DIFF);
    end else if (divTick) begin
      divCnt <= '0;
      if (lastTick) busyQ <= 1'b0;
      else          tickCnt <= tickCnt + TICK_W'(1);
    end else if (busyQ) begin
      divCnt <= divCnt + DIV_W'(1);
    end
  end

  always_comb begin
    strb             = '0;
    strb.startStb    = startOk && !softRst;
    strb.trialActive = busyQ && inTrial;
    strb.trialStb    = divTick && inTrial;
    strb.trialIdx    = IDX_W'(SAR_BITS - 1) - IDX_W'(trialOfs);
    strb.writeStb    = divTick && lastTick;
    strb.diffMode    = diffQ;
  end

  assign busy     = busyQ;
  assign sampleEn = busyQ && inAcq;

  assert_busy_from_start_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyQ) |-> $past(convStart && cfgEnable));

  assert_restart_ignored_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && convStart && !softRst && !(divTick && lastTick)) |=> (busyQ && (tickCnt != '0 || divCnt != '0)));

  assert_temp_timing_R5: assert property (@(posedge clk) disable iff (!rstN)
    (startOk && !softRst && cfgPos == CH_W'(TEMP_CH)) |=> (effDiv == DIV_W'(TEMP_DIV) && effAcq == ACQ_W'(TEMP_ACQ)));

  assert_timing_held_R12: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && !softRst) |=> ($stable(effAcq) && $stable(effDiv) && $stable(diffQ)));

  assert_trial_in_busy_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.trialStb |-> (busyQ && !sampleEn));

endmodule

// File: rtl/sar_seq_dp.sv
module sar_seq_dp
  import sar_seq_pkg::*;
#(
  parameter int ACQ_W = 8,
  parameter int DIV_W = 8,
  parameter int CH_W  = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic               regRdEn,
  input  logic [2:0]         regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  input  seqStrobe_t         strb,
  input  logic               cmpIn,
  output logic               softRst,
  output logic               cfgEnable,
  output inMode_e            cfgMode,
  output logic [ACQ_W-1:0]   cfgAcq,
  output logic [DIV_W-1:0]   cfgDiv,
  output logic [CH_W-1:0]    cfgPos,
  output logic [CH_W-1:0]    cfgNeg,
  output logic [SAR_BITS-1:0] trialCode,
  output logic               ready
);

  localparam logic [ACQ_W-1:0] ACQ_RST = ACQ_W'(8);
  localparam logic [DIV_W-1:0] DIV_RST = DIV_W'(2);
  localparam logic [SAR_BITS-1:0] MID_CODE = SAR_BITS'(1) << (SAR_BITS - 1);

  logic               enQ;
  inMode_e            modeQ;
  logic [ACQ_W-1:0]   acqQ;
  logic [DIV_W-1:0]   divQ;
  logic [CH_W-1:0]    posQ, negQ;
  logic               readyQ;
  logic [DATA_W-1:0]  dataQ;
  logic [SAR_BITS-1:0] sarQ;

  logic                wrCtrl, wrPos, wrNeg, rdData;
  logic [SAR_BITS-1:0] trialBit, outCode;
  logic [DATA_W-1:0]   fmtWord;

  assign softRst = regWrEn && (regAddr == ADDR_SRST);
  assign wrCtrl  = regWrEn && (regAddr == ADDR_CTRL);
  assign wrPos   = regWrEn && (regAddr == ADDR_POS);
  assign wrNeg   = regWrEn && (regAddr == ADDR_NEG);
  assign rdData  = regRdEn && (regAddr == ADDR_DATA);

  assign trialBit  = SAR_BITS'(1) << strb.trialIdx;
  assign trialCode = strb.trialActive ? (sarQ | trialBit) : sarQ;

  assign outCode = strb.diffMode ? (sarQ ^ MID_CODE) : sarQ;
  assign fmtWord = {{SIGN_W{strb.diffMode & outCode[SAR_BITS-1]}}, outCode, {DATA_LSB{1'b0}}};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ   <= 1'b0;
      modeQ <= MODE_SINGLE;
      acqQ  <= ACQ_RST;
      divQ  <= DIV_RST;
      posQ  <= '0;
      negQ  <= '0;
    end else if (softRst) begin
      enQ   <= 1'b0;
      modeQ <= MODE_SINGLE;
      acqQ  <= ACQ_RST;
      divQ  <= DIV_RST;
      posQ  <= '0;
      negQ  <= '0;
    end else begin
      if (wrCtrl) begin
        enQ   <= regWrData[0];
        modeQ <= inMode_e'(regWrData[2:1]);
        acqQ  <= regWrData[4 +: ACQ_W];
        divQ  <= regWrData[16 +: DIV_W];
      end
      if (wrPos) posQ <= regWrData[CH_W-1:0];
      if (wrNeg) negQ <= regWrData[CH_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sarQ   <= '0;
      dataQ  <= '0;
      readyQ <= 1'b0;
    end else if (softRst) begin
      sarQ   <= '0;
      dataQ  <= '0;
      readyQ <= 1'b0;
    end else begin
      if (strb.startStb)
        sarQ <= '0;
      else if (strb.trialStb && cmpIn)
        sarQ <= sarQ | trialBit;
      if (strb.writeStb) begin
        dataQ  <= fmtWord;
        readyQ <= 1'b1;
      end else if (rdData) begin
        readyQ <= 1'b0;
      end
    end
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_CTRL: begin
        regRdData[0]          = enQ;
        regRdData[2:1]        = modeQ;
        regRdData[4 +: ACQ_W] = acqQ;
        regRdData[16 +: DIV_W] = divQ;
      end
      ADDR_POS:  regRdData[CH_W-1:0] = posQ;
      ADDR_NEG:  regRdData[CH_W-1:0] = negQ;
      ADDR_STAT: regRdData[0] = readyQ;
      ADDR_DATA: regRdData = dataQ;
      default:   regRdData = '0;
    endcase
  end

  assign cfgEnable = enQ;
  assign cfgMode   = modeQ;
  assign cfgAcq    = acqQ;
  assign cfgDiv    = divQ;
  assign cfgPos    = posQ;
  assign cfgNeg    = negQ;
  assign ready     = readyQ;

  assert_ready_on_end_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.writeStb && !softRst) |=> readyQ);

  assert_read_clears_R10: assert property (@(posedge clk) disable iff (!rstN)
    (rdData && !strb.writeStb && !softRst) |=> !readyQ);

  assert_binary_pad_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.writeStb && !softRst && !strb.diffMode) |=> (dataQ[DATA_W-1 -: SIGN_W] == '0 && dataQ[DATA_LSB-1:0] == '0));

  assert_sign_copy_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.writeStb && !softRst && strb.diffMode) |=> (dataQ[DATA_W-1] == dataQ[DATA_LSB+SAR_BITS-1]));

  assert_reset_clears_R11: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> (!readyQ && !enQ && dataQ == '0));

endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
  import sar_seq_pkg::*;
#(
  parameter int ACQ_W    = 8,
  parameter int DIV_W    = 8,
  parameter int CH_W     = 4,
  parameter int TEMP_CH  = 9,
  parameter int TEMP_ACQ = 16,
  parameter int TEMP_DIV = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic        regRdEn,
  input  logic [2:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  input  logic        convStart,
  input  logic        cmpIn,
  output logic [11:0] trialCode,
  output logic        sampleEn,
  output logic        busy,
  output logic        irq,
  output logic [3:0]  chanPos,
  output logic [3:0]  chanNeg
);

  seqStrobe_t       strb;
  logic             softRst, cfgEnable, ready;
  inMode_e          cfgMode;
  logic [ACQ_W-1:0] cfgAcq;
  logic [DIV_W-1:0] cfgDiv;
  logic [CH_W-1:0]  cfgPos, cfgNeg;

  sar_seq_ctrl #(
    .ACQ_W(ACQ_W), .DIV_W(DIV_W), .CH_W(CH_W),
    .TEMP_CH(TEMP_CH), .TEMP_ACQ(TEMP_ACQ), .TEMP_DIV(TEMP_DIV)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .softRst(softRst), .convStart(convStart),
    .cfgEnable(cfgEnable), .cfgMode(cfgMode), .cfgAcq(cfgAcq), .cfgDiv(cfgDiv),
    .cfgPos(cfgPos), .strb(strb), .busy(busy), .sampleEn(sampleEn)
  );

  sar_seq_dp #(
    .ACQ_W(ACQ_W), .DIV_W(DIV_W), .CH_W(CH_W)
  ) i_dp (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .strb(strb), .cmpIn(cmpIn), .softRst(softRst), .cfgEnable(cfgEnable),
    .cfgMode(cfgMode), .cfgAcq(cfgAcq), .cfgDiv(cfgDiv), .cfgPos(cfgPos),
    .cfgNeg(cfgNeg), .trialCode(trialCode), .ready(ready)
  );

  assign irq     = ready;
  assign chanPos = 4'(cfgPos);
  assign chanNeg = 4'(cfgNeg);

endmodule

// File: tb/test_sar_conv_seq.sv
module test_sar_conv_seq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0, convStart = 1'b0;
  logic [2:0]  regAddr = 3'd0;
  logic [31:0] regWrData = 32'd0;
  logic [31:0] regRdData;
  logic [11:0] trialCode;
  logic        sampleEn, busy, irq, cmpIn;
  logic [3:0]  chanPos, chanNeg;
  int          vin = 0;
  int          checks = 0, failures = 0;
  bit          finished = 1'b0;

  always #4 clk = ~clk;

  assign cmpIn = (vin >= int'(trialCode));

  sar_conv_seq i_sar_conv_seq (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .convStart(convStart), .cmpIn(cmpIn), .trialCode(trialCode),
    .sampleEn(sampleEn), .busy(busy), .irq(irq), .chanPos(chanPos), .chanNeg(chanNeg)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkCtrl(input int en, input int mode, input int acq, input int dv);
    return 32'(en & 1) | (32'(mode & 3) << 1) | (32'(acq & 255) << 4) | (32'(dv & 255) << 16);
  endfunction

  function automatic logic [31:0] expWord(input int v, input bit diff);
    logic [11:0] c;
    c = 12'(v);
    if (diff) begin
      c = c ^ 12'h800;
      return {{4{c[11]}}, c, 16'h0};
    end
    return {4'h0, c, 16'h0};
  endfunction

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  // pokeKind: 0 none, 1 start, 2 control write, 3 data read, 4 soft reset
  task automatic runConv(input int v, input int pokeAt, input int pokeKind, input logic [31:0] pokeVal,
                         output int cyc, output int acqCyc, output logic [11:0] t2,
                         output logic [11:0] t3, output logic [11:0] t4);
    vin = v;
    @(negedge clk);
    convStart = 1'b1;
    @(negedge clk);
    convStart = 1'b0;
    cyc = 0; acqCyc = 0; t2 = '0; t3 = '0; t4 = '0;
    while (busy && cyc < 5000) begin
      cyc++;
      if (sampleEn) acqCyc++;
      if (cyc == 2) t2 = trialCode;
      if (cyc == 3) t3 = trialCode;
      if (cyc == 4) t4 = trialCode;
      if (cyc == pokeAt) begin
        case (pokeKind)
          1: convStart = 1'b1;
          2: begin regWrEn = 1'b1; regAddr = 3'd0; regWrData = pokeVal; end
          3: begin regRdEn = 1'b1; regAddr = 3'd4; end
          4: begin regWrEn = 1'b1; regAddr = 3'd5; end
          default: ;
        endcase
      end else begin
        convStart = 1'b0; regWrEn = 1'b0; regRdEn = 1'b0;
      end
      @(negedge clk);
    end
    convStart = 1'b0; regWrEn = 1'b0; regRdEn = 1'b0;
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(8 * 190000);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    logic [31:0] r;
    int cyc, acq;
    logic [11:0] t2, t3, t4;
    int sweepBad;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(3'd0, r); chk("R1 ctrl", r, 32'h0002_0080);
    rd(3'd1, r); chk("R1 pos", r, 0);
    rd(3'd2, r); chk("R1 neg", r, 0);
    rd(3'd3, r); chk("R1 status", r, 0);
    rd(3'd4, r); chk("R1 data", r, 0);
    chk("R1 busy irq", {30'd0, busy, irq}, 0);

    // R2 start ignored when disabled
    @(negedge clk); convStart = 1'b1;
    @(negedge clk); convStart = 1'b0;
    chk("R2 disabled start", {31'd0, busy}, 0);
    @(negedge clk);
    chk("R2 disabled start later", {31'd0, busy}, 0);

    // default timing, R2 R4 R6 R7 R9 R10
    wr(3'd1, 32'd2);
    chk("chanPos out", {28'd0, chanPos}, 32'd2);
    wr(3'd0, mkCtrl(1, 0, 8, 2));
    runConv(12'h555, 0, 0, 0, cyc, acq, t2, t3, t4);
    chk("R2 default busy length", cyc, 54);
    chk("R4 default acq length", acq, 16);
    chk("R9 irq after end", {31'd0, irq}, 1);
    rd(3'd3, r); chk("R9 ready bit", r, 1);
    rd(3'd4, r); chk("R7 data 0x555", r, expWord(12'h555, 0));
    rd(3'd3, r); chk("R10 ready cleared", r, 0);
    chk("R10 irq cleared", {31'd0, irq}, 0);

    wr(3'd0, mkCtrl(1, 0, 1, 1));
    runConv(12'h555, 0, 0, 0, cyc, acq, t2, t3, t4);
    chk("R6 first trial MSB", t2, 12'h800);
    chk("R6 second trial", t3, 12'h400);
    chk("R6 third trial keeps bit", t4, 12'h600);
    chk("R6 final code", trialCode, 12'h555);
    rd(3'd4, r);

    // R6/R7 sweep, straight binary
    sweepBad = 0;
    for (int v = 0; v < 4096; v += 7) begin
      runConv(v, 0, 0, 0, cyc, acq, t2, t3, t4);
      rd(3'd4, r);
      if (r !== expWord(v, 0) || cyc != 20) begin
        sweepBad++;
        $display("FAIL R7 sweep v=%0d actual=0x%08h expected=0x%08h cyc=%0d", v, r, expWord(v, 0), cyc);
      end
    end
    chk("R7 sweep mismatches", sweepBad, 0);
    foreach (t2[i]) ;
    runConv(4095, 0, 0, 0, cyc, acq, t2, t3, t4); rd(3'd4, r);
    chk("R6 full scale", r, expWord(4095, 0));
    runConv(2048, 0, 0, 0, cyc, acq, t2, t3, t4); rd(3'd4, r);
    chk("R6 exact trial level", r, expWord(2048, 0));

    // R8 fully differential
    wr(3'd0, mkCtrl(1, 2, 1, 1));
    sweepBad = 0;
    for (int v = 0; v < 4096; v += 61) begin
      runConv(v, 0, 0, 0, cyc, acq, t2, t3, t4);
      rd(3'd4, r);
      if (r !== expWord(v, 1)) begin
        sweepBad++;
        $display("FAIL R8 sweep v=%0d actual=0x%08h expected=0x%08h", v, r, expWord(v, 1));
      end
    end
    chk("R8 sweep mismatches", sweepBad, 0);
    runConv(12'h800, 0, 0, 0, cyc, acq, t2, t3, t4); rd(3'd4, r);
    chk("R8 mid-scale is zero", r, 32'h0);
    runConv(12'h7FF, 0, 0, 0, cyc, acq, t2, t3, t4); rd(3'd4, r);
    chk("R8 minus one", r, 32'hFFFF_0000);
    runConv(0, 0, 0, 0, cyc, acq, t2, t3, t4); rd(3'd4, r);
    chk("R8 negative full scale", r, 32'hF800_0000);
    runConv(4095, 0, 0, 0, cyc, acq, t2, t3, t4); rd(3'd4, r);
    chk("R8 positive full scale", r, 32'h07FF_0000);

    // R7 spare mode is straight binary
    wr(3'd0, mkCtrl(1, 3, 1, 1));
    runConv(12'h9AB, 0, 0, 0, cyc, acq, t2, t3, t4); rd(3'd4, r);
    chk("R7 mode 3 binary", r, expWord(12'h9AB, 0));

    // R5 temperature override and restore
    wr(3'd0, mkCtrl(1, 0, 2, 3));
    wr(3'd1, 32'd9);
    runConv(12'h321, 0, 0, 0, cyc, acq, t2, t3, t4); rd(3'd4, r);
    chk("R5 temp busy length", cyc, (16 + 19) * 32);
    chk("R5 temp acq length", acq, 16 * 32);
    chk("R5 temp data", r, expWord(12'h321, 0));
    wr(3'd1, 32'd3);
    runConv(12'h321, 0, 0, 0, cyc, acq, t2, t3, t4); rd(3'd4, r);
    chk("R5 user timing restored", cyc, (2 + 19) * 3);
    chk("R5 user acq restored", acq, 2 * 3);

    // R4 zero values act as one
    wr(3'd0, mkCtrl(1, 0, 0, 0));
    runConv(12'h0F0, 0, 0, 0, cyc, acq, t2, t3, t4); rd(3'd4, r);
    chk("R4 zero settings length", cyc, 20);
    chk("R4 zero settings acq", acq, 1);

    // R3 restart while busy ignored
    wr(3'd0, mkCtrl(1, 0, 2, 2));
    runConv(12'hABC, 10, 1, 0, cyc, acq, t2, t3, t4);
    chk("R3 length unchanged", cyc, 42);
    repeat (50) @(negedge clk);
    chk("R3 no second conversion", {31'd0, busy}, 0);
    rd(3'd4, r); chk("R3 data intact", r, expWord(12'hABC, 0));

    // R12 control write mid-conversion
    wr(3'd0, mkCtrl(1, 0, 2, 1));
    runConv(12'h123, 3, 2, mkCtrl(1, 2, 10, 4), cyc, acq, t2, t3, t4);
    chk("R12 length held", cyc, 21);
    rd(3'd4, r); chk("R12 format held", r, expWord(12'h123, 0));

    // R10 read on the final cycle: set wins
    wr(3'd0, mkCtrl(1, 0, 2, 1));
    runConv(12'h456, 21, 3, 0, cyc, acq, t2, t3, t4);
    chk("R10 length", cyc, 21);
    rd(3'd3, r); chk("R10 set wins over read", r, 1);
    rd(3'd4, r); chk("R10 new data", r, expWord(12'h456, 0));

    // R11 soft reset mid-conversion
    wr(3'd1, 32'd5); wr(3'd2, 32'd6);
    chk("chanNeg out", {28'd0, chanNeg}, 32'd6);
    runConv(12'h777, 5, 4, 0, cyc, acq, t2, t3, t4);
    chk("R11 busy dropped", cyc, 5);
    rd(3'd0, r); chk("R11 ctrl default", r, 32'h0002_0080);
    rd(3'd1, r); chk("R11 pos default", r, 0);
    rd(3'd2, r); chk("R11 neg default", r, 0);
    rd(3'd3, r); chk("R11 no ready", r, 0);
    rd(3'd4, r); chk("R11 data default", r, 0);
    repeat (60) @(negedge clk);
    chk("R11 irq stays low", {30'd0, irq, busy}, 0);

    finished = 1'b1;
    summary();
  end

endmodule